// File: doc/BRIEF.md
# Lagged-XOR Byte Sequence Generator

This block produces an endless stream of 8-bit elements on a valid/ready output. The stream opens with four fixed seed bytes. Every later byte is the XOR of three earlier stream elements, taken four, three and one positions back from the byte being made. A consumer pulls bytes at its own pace: the stream moves forward only when a byte is accepted, and a byte that has not been taken stays on the output.

A four-entry window keeps the most recent elements. A small phase counter chooses between the seed bytes and the XOR result. A one-cycle restart input, or the active-low reset, sends the stream back to its first seed byte. Because no input other than restart and the handshake affects the output, the sequence can be replayed exactly. This makes the block useful as a deterministic test-pattern or scrambling source.

Top module: `lxg_gen`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid is 0 after that edge. The first rising edge with rst_n high sets out_valid to 1, and it stays 1 until the next reset.
- R2: The first four elements after reset or restart are 0x3F, 0xE2, 0x65, 0xCA, in that order. 0x3F is on out_data in the first cycle out_valid is high.
- R3: For n of 4 or more, element s[n] equals s[n-4] XOR s[n-3] XOR s[n-1]. This gives s[4] = 0x17 and s[5] = 0x90.
- R4: The stream advances by one element only at a rising edge where out_valid and out_ready are both 1. At any other edge out_data keeps its value.
- R5: restart high at a rising edge puts 0x3F (element 0) on out_data after that edge, with out_valid still 1. This holds whatever out_ready is, and also during the seed phase. restart takes priority over a handshake at the same edge.
- R6: After a restart or a reset, the stream repeats the same sequence element for element, for at least 64 elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous one-cycle request to restart the stream at its first seed byte |
| out_ready | input | 1 | Consumer accepts out_data at this edge |
| out_valid | output | 1 | out_data holds a stream element |
| out_data | output | 8 | Current stream element |

## Verification
A corrupted history entry never shows up in the seed bytes. It first appears in the first computed byte, which is the fifth element. From then on the fault spreads into every following element, so a comparison over a long run cannot miss it. A phase counter that is off by one shifts or repeats a seed byte, which can be seen within four accepted outputs. A handshake fault shows up at once as a skipped or repeated element in the cycle after an edge where out_ready is low.

// File: rtl/lxg_pkg.sv
// Shared widths, seed constants and tap positions for the lagged-XOR generator.
// Assumes a four-element seed and a four-entry history window.
package lxg_pkg;
    parameter int ELEM_W   = 8;
    parameter int SEED_LEN = 4;
    parameter int HIST_LEN = 4;
    parameter int TAP_NUM  = 3;
    // Window positions feeding the XOR; position 0 is the oldest entry.
    parameter int TAP_POS [TAP_NUM] = '{0, 1, 3};

    typedef logic [ELEM_W-1:0] elem_t;

    // Seed byte selected by its position in the opening sequence.
    function automatic elem_t seed_byte(input int unsigned pos);
        case (pos)
            0:       seed_byte = 8'h3F;
            1:       seed_byte = 8'hE2;
            2:       seed_byte = 8'h65;
            default: seed_byte = 8'hCA;
        endcase
    endfunction
endpackage

// File: rtl/lxg_seed_phase.sv
// Seed phase tracker: counts accepted elements during the opening seed and
// drops the seeding flag once the last seed byte has been accepted.
// Assumes advance is only asserted for an accepted output.
module lxg_seed_phase #(
    parameter int SEED_LEN = 4,
    localparam int IDX_W   = (SEED_LEN > 1) ? $clog2(SEED_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    output logic             seeding,
    output logic [IDX_W-1:0] seed_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEED_LEN - 1);

    // Step through seed positions, then stay in the computed phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seeding  <= 1'b1;
            seed_idx <= '0;
        end else if (advance && seeding) begin
            if (seed_idx == LAST_IDX) begin
                seeding  <= 1'b0;
                seed_idx <= '0;
            end else begin
                seed_idx <= seed_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lxg_history.sv
// History window: a shift register of the most recent stream elements.
// Entry 0 is the oldest; new elements enter at the top entry.
// Assumes shift_en is high only when an element is accepted.
module lxg_history #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      shift_en,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   window
);
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_entry
            // One window entry: clears, or takes its newer neighbour on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    window[g] <= '0;
                end else if (shift_en) begin
                    if (g == DEPTH - 1) window[g] <= din;
                    else                window[g] <= window[(g + 1) % DEPTH];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lxg_xor_tap.sv
// Tap combiner: XOR of the window entries named in TAPS.
// Assumes every tap position is below DEPTH.
module lxg_xor_tap #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int NTAPS = 3,
    parameter int TAPS [NTAPS] = '{0, 1, 3}
) (
    input  logic [DEPTH-1:0][W-1:0] window,
    output logic [W-1:0]            mix
);
    // Fold the selected entries together.
    always_comb begin
        mix = '0;
        for (int t = 0; t < NTAPS; t++) mix = mix ^ window[TAPS[t]];
    end
endmodule

// File: rtl/lxg_gen.sv
// Lagged-XOR byte generator top. It emits the seed bytes, then XOR products
// of the history window, and advances one element per valid/ready handshake.
// restart and rst_n are both synchronous; restart wins over a handshake.
module lxg_gen
    import lxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_data
);
    localparam int IDX_W = (SEED_LEN > 1) ? $clog2(SEED_LEN) : 1;

    logic                             valid_q;
    logic                             accept;
    logic                             seeding;
    logic [IDX_W-1:0]                 seed_idx;
    logic [HIST_LEN-1:0][ELEM_W-1:0]  window;
    logic [ELEM_W-1:0]                mix;
    logic [ELEM_W-1:0]                cur_elem;

    // Output valid: low in reset, high from the first edge after it.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    // Handshake qualifier; a restart on the same edge overrides it.
    assign accept = valid_q && out_ready && !restart;

    lxg_seed_phase #(.SEED_LEN(SEED_LEN)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .advance  (accept),
        .seeding  (seeding),
        .seed_idx (seed_idx)
    );

    lxg_history #(.W(ELEM_W), .DEPTH(HIST_LEN)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .shift_en (accept),
        .din      (cur_elem),
        .window   (window)
    );

    lxg_xor_tap #(.W(ELEM_W), .DEPTH(HIST_LEN), .NTAPS(TAP_NUM), .TAPS(TAP_POS)) tap_i (
        .window (window),
        .mix    (mix)
    );

    // Element on offer: a seed byte during the seed phase, else the XOR product.
    always_comb begin
        if (seeding) cur_elem = seed_byte(32'(seed_idx));
        else         cur_elem = mix;
    end

    assign out_valid = valid_q;
    assign out_data  = cur_elem;
endmodule

// File: rtl/lxg_gen_chk.sv
// Property checker for lxg_gen, attached by bind. It keeps its own window of
// accepted elements to check the seed order and the recurrence.
module lxg_gen_chk
    import lxg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              out_ready,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_data
);
    logic [ELEM_W-1:0] seen [HIST_LEN];
    logic [2:0]        seen_cnt;

    // Track the last accepted elements and how many have been accepted, up to four.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seen_cnt <= '0;
            for (int i = 0; i < HIST_LEN; i++) seen[i] <= '0;
        end else if (out_valid && out_ready) begin
            for (int i = 0; i < HIST_LEN - 1; i++) seen[i] <= seen[i + 1];
            seen[HIST_LEN - 1] <= out_data;
            if (seen_cnt < 3'd4) seen_cnt <= seen_cnt + 3'd1;
        end
    end

    a_r1_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_valid);

    a_r2_seed_order: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (out_valid && seen_cnt < 3'd4) |-> out_data == seed_byte(32'(seen_cnt)));

    a_r3_recurrence: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (out_valid && seen_cnt == 3'd4) |-> out_data == (seen[0] ^ seen[1] ^ seen[3]));

    a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=> $stable(out_data));

    a_r5_restart_head: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (out_valid && out_data == 8'h3F));
endmodule

bind lxg_gen lxg_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/lxg_gen_tb_top.sv
// Bench for lxg_gen: a behavioural model of the stream, compared every cycle.
module lxg_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    bit done = 1'b0;
    byte unsigned ref_s [$];

    always #10 clk = ~clk;

    lxg_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle starting at a negedge: drive, let the edge pass, update the model, check.
    task automatic step(input bit rdy, input bit rs, input string tag);
        string req;
        out_ready = rdy;
        restart   = rs;
        @(posedge clk);
        if (rs)       idx = 0;
        else if (rdy) idx++;
        @(negedge clk);
        if (tag != "")   req = tag;
        else if (rs)     req = "R5";
        else if (!rdy)   req = "R4";
        else if (idx < 4) req = "R2";
        else             req = "R3";
        check(out_valid === 1'b1, req, out_valid, 1);
        check(out_data === ref_s[idx], req, out_data, ref_s[idx]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        ref_s = '{8'h3F, 8'hE2, 8'h65, 8'hCA};
        for (int n = 4; n < 400; n++) ref_s.push_back(ref_s[n-4] ^ ref_s[n-3] ^ ref_s[n-1]);

        // R1: reset holds valid low
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", out_valid, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b1, "R1", out_valid, 1);
        check(out_data === 8'h3F, "R2", out_data, 8'h3F);

        // R2 then R3: seed then the first computed bytes, known values
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "");
        check(ref_s[4] == 8'h17 && ref_s[5] == 8'h90, "R3", ref_s[4], 8'h17);

        // R4: stalls and a mixed acceptance pattern against the model
        for (int i = 0; i < 120; i++) step(($urandom_range(0, 3) != 0), 1'b0, "");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R4");

        // R5: restart with ready high, then during the seed, then with ready low
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, "");
        step(1'b1, 1'b0, "");
        step(1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, "");

        // R6: replay after restart for 70 elements
        step(1'b0, 1'b1, "R5");
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, "R6");

        // R1 and R6: reset mid-stream, then the same sequence again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R1", out_valid, 0);
        rst_n = 1'b1;
        idx = 0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b1 && out_data === 8'h3F, "R1", out_data, 8'h3F);
        for (int i = 0; i < 66; i++) step(1'b1, 1'b0, "R6");

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end
endmodule